// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master from a fast system clock. A programmable divider first turns the system clock into a slower module tick. Two phase counters, one for the low half and one for the high half of SCL, then count module ticks. Each phase lasts its programmed count plus a small fixed offset. The offset models the pipeline delay of the bit engine and depends on the divider setting. A build parameter selects a variant in which the offset is constant.

The configuration is taken only while the enable input is low, which matches the controller being held in reset. Raising the enable starts the clock with a low phase. A single-cycle pulse marks every phase boundary so that the bit-level controller can time its SDA changes. If the programmed high count is zero the setting is illegal: SCL is then held high and no boundary pulses are produced.

States of the phase sequencer:
- `ST_IDLE`: the block is disabled and SCL is high.
- `ST_LOW`: SCL is driven low.
- `ST_HIGH`: SCL is released high.
- `ST_HALT`: the high count is zero and SCL is held high.

Transitions:
- IDLE→LOW when enabled with a nonzero high count.
- IDLE→HALT when enabled with a zero high count.
- LOW→HIGH when the low count expires on a module tick.
- HIGH→LOW when the high count expires on a module tick.
- Any state→IDLE when the enable is low.

Top module: `scl_clock_gen`

## Requirements
- R1: One module tick occurs every (prescale + 1) system clocks, so both phase widths scale by (prescale + 1).
- R2: The SCL low phase lasts (low_cnt + d) × (prescale + 1) system clocks.
- R3: The SCL high phase lasts (high_cnt + d) × (prescale + 1) system clocks.
- R4: With FIXED_OFFSET = 0, the offset d is 7 for prescale 0, 6 for prescale 1, and 5 for prescale 2 or more.
- R5: With FIXED_OFFSET = 1, d is 6 for every prescale value.
- R6: A captured high count of zero holds SCL high and suppresses every boundary pulse for as long as the block stays enabled.
- R7: prescale, low_cnt and high_cnt are captured only while run_en_i is low. Changes made while the block is enabled have no effect on the waveform.
- R8: One clock after run_en_i is sampled low, SCL is high. One clock after run_en_i is sampled high from the idle state, SCL goes low and the full low phase begins.
- R9: While the block is running, phase_tc_o is a one-cycle pulse in exactly the cycle in which SCL changes level at a phase boundary.
- R10: After reset, scl_o is 1 and phase_tc_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Enable. Low means held in reset and configuration is captured; high means running |
| prescale_i | input | PSC_W | Module clock divider minus one |
| low_cnt_i | input | CNT_W | Low-phase count before the offset is added |
| high_cnt_i | input | CNT_W | High-phase count before the offset is added; zero is illegal |
| scl_o | output | 1 | Registered SCL level |
| phase_tc_o | output | 1 | One-cycle pulse at each SCL phase boundary |

## Verification
A module tick and the expiry of a phase count meet in the same cycle at every boundary. When the prescale is 0, a tick falls in every cycle, so a counter reload and a state change coincide cycle after cycle. The bench provokes this with prescale values 0, 1, 3 and others, and with low_cnt set to 0. Each measured width is judged against the formula, and the boundary pulse must appear on the first high cycle and only there. A second collision is a disable or a configuration change arriving in the middle of a phase. The bench checks that SCL returns high one clock later and that the old settings still rule a running clock.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_HALT = 2'd3
    } scl_state_e;

    localparam logic [2:0] OFFS_PSC0  = 3'd7;
    localparam logic [2:0] OFFS_PSC1  = 3'd6;
    localparam logic [2:0] OFFS_OTHER = 3'd5;
    localparam logic [2:0] OFFS_FIXED = 3'd6;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PSC_W'(1);
        end
    end

endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
    import scl_gen_pkg::*;
#(
    parameter int PSC_W        = 8,
    parameter int CNT_W        = 12,
    parameter bit FIXED_OFFSET = 1'b0,
    localparam int LEN_W       = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic [PSC_W-1:0] prescale_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    output logic [PSC_W-1:0] prescale_o,
    output logic [LEN_W-1:0] low_len_o,
    output logic [LEN_W-1:0] high_len_o,
    output logic             high_zero_o
);

    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] high_q;
    logic [2:0]       offs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (!run_en_i) begin
            psc_q  <= prescale_i;
            low_q  <= low_cnt_i;
            high_q <= high_cnt_i;
        end
    end

    generate
        if (FIXED_OFFSET) begin : g_fixed
            assign offs = OFFS_FIXED;
        end else begin : g_scaled
            always_comb begin
                if (psc_q == '0)
                    offs = OFFS_PSC0;
                else if (psc_q == PSC_W'(1))
                    offs = OFFS_PSC1;
                else
                    offs = OFFS_OTHER;
            end
        end
    endgenerate

    assign prescale_o  = psc_q;
    assign low_len_o   = {1'b0, low_q}  + LEN_W'(offs);
    assign high_len_o  = {1'b0, high_q} + LEN_W'(offs);
    assign high_zero_o = (high_q == '0);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    input  logic             high_zero_i,
    output logic             presc_run_o,
    output logic             scl_o,
    output logic             tc_o,
    output scl_state_e       state_o
);

    scl_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             boundary;
    logic             scl_q, tc_q;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        boundary = 1'b0;
        if (!run_en_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (high_zero_i) begin
                        state_d = ST_HALT;
                    end else begin
                        state_d = ST_LOW;
                        cnt_d   = low_len_i - LEN_W'(1);
                    end
                end
                ST_LOW: begin
                    if (tick_i) begin
                        if (cnt_q == '0) begin
                            state_d  = ST_HIGH;
                            cnt_d    = high_len_i - LEN_W'(1);
                            boundary = 1'b1;
                        end else begin
                            cnt_d = cnt_q - LEN_W'(1);
                        end
                    end
                end
                ST_HIGH: begin
                    if (tick_i) begin
                        if (cnt_q == '0) begin
                            state_d  = ST_LOW;
                            cnt_d    = low_len_i - LEN_W'(1);
                            boundary = 1'b1;
                        end else begin
                            cnt_d = cnt_q - LEN_W'(1);
                        end
                    end
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            tc_q  <= 1'b0;
        end else begin
            scl_q <= (state_d != ST_LOW);
            tc_q  <= boundary;
        end
    end

    assign presc_run_o = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign scl_o       = scl_q;
    assign tc_o        = tc_q;
    assign state_o     = state_q;

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W        = 8,
    parameter int CNT_W        = 12,
    parameter bit FIXED_OFFSET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic [PSC_W-1:0] prescale_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    output logic             scl_o,
    output logic             phase_tc_o
);

    localparam int LEN_W = CNT_W + 1;

    logic [PSC_W-1:0] psc_cfg;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             high_zero;
    logic             presc_run;
    logic             tick;
    scl_state_e       fsm_state;

    scl_cfg_latch #(
        .PSC_W        (PSC_W),
        .CNT_W        (CNT_W),
        .FIXED_OFFSET (FIXED_OFFSET)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en_i    (run_en_i),
        .prescale_i  (prescale_i),
        .low_cnt_i   (low_cnt_i),
        .high_cnt_i  (high_cnt_i),
        .prescale_o  (psc_cfg),
        .low_len_o   (low_len),
        .high_len_o  (high_len),
        .high_zero_o (high_zero)
    );

    scl_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (presc_run),
        .div_i  (psc_cfg),
        .tick_o (tick)
    );

    scl_phase_fsm #(
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en_i    (run_en_i),
        .tick_i      (tick),
        .low_len_i   (low_len),
        .high_len_i  (high_len),
        .high_zero_i (high_zero),
        .presc_run_o (presc_run),
        .scl_o       (scl_o),
        .tc_o        (phase_tc_o),
        .state_o     (fsm_state)
    );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk
    import scl_gen_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       run_en_i,
    input logic       scl_o,
    input logic       phase_tc_o,
    input scl_state_e fsm_state,
    input logic       high_zero
);

    // R8
    scl_high_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> scl_o);

    // R9
    tc_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tc_o |-> (scl_o != $past(scl_o)));

    // R9
    rise_has_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && $past(run_en_i) && $rose(scl_o)) |-> phase_tc_o);

    // R6
    zero_high_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && high_zero) |-> !phase_tc_o);

    // R9
    steady_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == ST_LOW || fsm_state == ST_HIGH) &&
         ($past(fsm_state) == ST_LOW || $past(fsm_state) == ST_HIGH) &&
         !phase_tc_o) |-> $stable(scl_o));

endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en_i   (run_en_i),
    .scl_o      (scl_o),
    .phase_tc_o (phase_tc_o),
    .fsm_state  (fsm_state),
    .high_zero  (high_zero)
);

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int PSC_W      = 8;
    localparam int CNT_W      = 12;
    localparam int NVEC       = 6;
    localparam int MAX_CYC    = 150000;
    // prescale, low, high
    localparam int VEC [NVEC][3] = '{
        '{0, 10, 8}, '{1, 10, 8}, '{3, 12, 6},
        '{2, 0, 1},  '{0, 0, 1},  '{5, 3, 20}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, run_en_f = 1'b0;
    logic [PSC_W-1:0] psc = '0;
    logic [CNT_W-1:0] lowc = '0, highc = '0;
    logic scl, tc, scl_f, tc_f;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_clock_gen #(.PSC_W(PSC_W), .CNT_W(CNT_W), .FIXED_OFFSET(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .prescale_i(psc),
        .low_cnt_i(lowc), .high_cnt_i(highc), .scl_o(scl), .phase_tc_o(tc));

    scl_clock_gen #(.PSC_W(PSC_W), .CNT_W(CNT_W), .FIXED_OFFSET(1'b1)) uut_fix (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en_f), .prescale_i(psc),
        .low_cnt_i(lowc), .high_cnt_i(highc), .scl_o(scl_f), .phase_tc_o(tc_f));

    function automatic int offs(input int p, input bit fixed);
        if (fixed) return 6;
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    function automatic logic sel_scl(input bit f);
        return f ? scl_f : scl;
    endfunction

    function automatic logic sel_tc(input bit f);
        return f ? tc_f : tc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts one low phase then one high phase, sampled at negedges
    task automatic measure(input bit f, output int lo, output int hi, output int tcs, output int tc_first);
        int n = 0;
        while (sel_scl(f) != 1'b0 && n < 5000) begin @(negedge clk); n++; end
        lo = 0;
        while (sel_scl(f) == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
        tc_first = int'(sel_tc(f));
        hi = 0; tcs = 0;
        while (sel_scl(f) == 1'b1 && hi < 5000) begin
            tcs += int'(sel_tc(f));
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input bit f, input int p, input int l, input int h, input string tag);
        int lo, hi, tcs, tf, lo2, hi2, tcs2, tf2, d;
        d = offs(p, f);
        @(negedge clk);
        run_en = 1'b0; run_en_f = 1'b0;
        psc = PSC_W'(p); lowc = CNT_W'(l); highc = CNT_W'(h);
        @(negedge clk);
        if (f) run_en_f = 1'b1; else run_en = 1'b1;
        @(negedge clk);
        // R8: low phase starts one clock after enable
        check(sel_scl(f) == 1'b0, {tag, " R8 start low"}, int'(sel_scl(f)), 0);
        measure(f, lo, hi, tcs, tf);
        // R1 R2 R4/R5
        check(lo == (l + d) * (p + 1), {tag, " R2 low width"}, lo, (l + d) * (p + 1));
        // R3 R1
        check(hi == (h + d) * (p + 1), {tag, " R3 high width"}, hi, (h + d) * (p + 1));
        // R9
        check(tf == 1 && tcs == 1, {tag, " R9 boundary pulse"}, tcs * 10 + tf, 11);
        measure(f, lo2, hi2, tcs2, tf2);
        check(lo2 == (l + d) * (p + 1), {tag, " R2 second low"}, lo2, (l + d) * (p + 1));
    endtask

    initial begin
        while (!done && cyc < MAX_CYC) @(negedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, MAX_CYC);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lo, hi, tcs, tf, seen;
        repeat (3) @(negedge clk);
        // R10
        check(scl == 1'b1 && tc == 1'b0, "R10 reset idle", int'(scl) * 2 + int'(tc), 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(scl == 1'b1 && tc == 1'b0, "R10 after reset", int'(scl) * 2 + int'(tc), 2);

        for (int i = 0; i < NVEC; i++) begin
            // R4 table sweep
            run_vec(1'b0, VEC[i][0], VEC[i][1], VEC[i][2], "R4 vec");
        end

        // R5 fixed offset variant
        run_vec(1'b1, 0, 4, 2, "R5 fix psc0");
        run_vec(1'b1, 3, 4, 2, "R5 fix psc3");
        run_en_f = 1'b0;

        // R7 changes while running are ignored
        run_vec(1'b0, 0, 4, 4, "R7 base");
        psc = PSC_W'(3); lowc = CNT_W'(20); highc = '0;
        measure(1'b0, lo, hi, tcs, tf);
        check(lo == 11 && hi == 11, "R7 config ignored", lo * 100 + hi, 1111);

        // R8 disable mid-phase returns SCL high
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(scl == 1'b1, "R8 high after disable", int'(scl), 1);

        // R6 zero high count captured while disabled
        @(negedge clk);
        run_en = 1'b1;
        seen = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (scl != 1'b1 || tc != 1'b0) seen++;
        end
        check(seen == 0, "R6 zero high holds SCL", seen, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule